// File: doc/BRIEF.md
# Instruction Decoder and Control Unit

This block turns one 16-bit instruction word into the full set of control strobes that a single-cycle processor datapath needs. It has no state: every output follows the instruction word within the same cycle. The outputs are the ALU function, the register-file write enable and the destination address, the choice between a register and an immediate as the second ALU operand, the data-memory load and store enables, the control-flow flags, and the register addresses pulled from the word.

The word is split into four 4-bit fields. The top nibble is the opcode. Below it are the first source register, the second source register, and the low nibble. The low nibble is either the destination register or a signed offset. For a jump, the bits below the opcode form a 12-bit target offset. The destination address switches between the second-source field (for loads) and the low field (for arithmetic). The low field is also sign-extended to datapath width so that it can serve as an address offset or a branch offset. Registers 0 and 1 hold fixed values, so the decoder never enables a write to either of them.

Top module: `instr_decoder`

## Requirements
- R1: `rsAddr` always equals bits [11:8], `rtAddr` always equals bits [7:4] and `rdAddr` always equals bits [3:0], for every opcode.
- R2: Opcodes 0010, 0011, 0100 and 0101 set `aluOp` to 00 (add), 01 (subtract), 10 (AND) and 11 (OR) respectively. They set `dstSelRt`=0 and `aluSrcImm`=0 and leave both memory enables at 0. `regWrite` follows R9.
- R3: Opcode 0000 (load) sets `memLoad`=1, `dstSelRt`=1, `aluSrcImm`=1 and `aluOp`=00. `memStore` is 0 and `regWrite` follows R9.
- R4: Opcode 0001 (store) sets `memStore`=1, `aluSrcImm`=1 and `aluOp`=00. `regWrite`, `memLoad` and `dstSelRt` are 0.
- R5: Opcode 0111 (branch-if-equal) sets `branchFlag`=1 and `aluOp`=01. Every write and memory enable, `aluSrcImm` and `dstSelRt` are 0.
- R6: Opcode 1000 (jump) sets `jumpFlag`=1 with every write and memory enable at 0 and `aluOp`=00. `jumpOffset` always equals bits [11:0] of the word, whatever the opcode.
- R7: `immExt` is bits [3:0] sign-extended to 16 bits for every word. For example, 1000 gives 0xFFF8, 1110 gives 0xFFFE and 0111 gives 0x0007.
- R8: Opcode 1111 sets `haltFlag`=1 and nothing else. Opcodes 0110 and 1001 to 1110 drive every flag, enable and select to 0 and `aluOp` to 00. At most one of `branchFlag`, `jumpFlag` and `haltFlag` is ever 1.
- R9: `wrAddr` is `rtAddr` when `dstSelRt`=1 and `rdAddr` otherwise. `regWrite` is 1 only for the arithmetic opcodes and load, and only when `wrAddr` is neither 0 nor 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 16 | Instruction word being decoded |
| aluOp | output | 2 | ALU function: 00 add, 01 subtract, 10 AND, 11 OR |
| regWrite | output | 1 | Register-file write enable |
| dstSelRt | output | 1 | Destination taken from bits [7:4] (1) or bits [3:0] (0) |
| wrAddr | output | 4 | Selected destination register address |
| aluSrcImm | output | 1 | ALU second operand is `immExt` (1) or a register (0) |
| memLoad | output | 1 | Data-memory read enable |
| memStore | output | 1 | Data-memory write enable |
| branchFlag | output | 1 | Conditional branch instruction |
| jumpFlag | output | 1 | Unconditional jump instruction |
| haltFlag | output | 1 | Halt instruction |
| rsAddr | output | 4 | First source register address |
| rtAddr | output | 4 | Second source register address |
| rdAddr | output | 4 | Low field as a register address |
| immExt | output | 16 | Sign-extended low-field offset |
| jumpOffset | output | 12 | Jump target offset, bits [11:0] |

## Verification
The hardest case to reach is one where two decode rules interact. The write protection must cut off `regWrite` only when the selected destination is register 0 or 1. That destination comes from one field for loads and from another field for arithmetic, so a protected number in the field that is not selected must have no effect. The stimulus covers this by sweeping every value of all three register fields under every opcode. A load that names register 1 as its target, with a free register in the low field, is then checked against an arithmetic word with the fields swapped. Directed words also pin down the sign-extension end values.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

  typedef logic [3:0] opcodeT;

  localparam opcodeT OPC_LOAD  = 4'b0000;
  localparam opcodeT OPC_STORE = 4'b0001;
  localparam opcodeT OPC_ADD   = 4'b0010;
  localparam opcodeT OPC_SUB   = 4'b0011;
  localparam opcodeT OPC_AND   = 4'b0100;
  localparam opcodeT OPC_OR    = 4'b0101;
  localparam opcodeT OPC_BEQ   = 4'b0111;
  localparam opcodeT OPC_JUMP  = 4'b1000;
  localparam opcodeT OPC_HALT  = 4'b1111;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_AND = 2'b10,
    ALU_OR  = 2'b11
  } aluOpT;

  typedef struct packed {
    aluOpT aluOp;
    logic  wantWrite;
    logic  dstSelRt;
    logic  aluSrcImm;
    logic  memLoad;
    logic  memStore;
    logic  branch;
    logic  jump;
    logic  halt;
  } ctrlStrobesT;

endpackage

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import instr_dec_pkg::*;
(
  input  opcodeT      opcode,
  output ctrlStrobesT strobes
);

  always_comb begin
    strobes = '0;
    strobes.aluOp = ALU_ADD;
    unique case (opcode)
      OPC_ADD: begin
        strobes.aluOp = ALU_ADD;
        strobes.wantWrite = 1'b1;
      end
      OPC_SUB: begin
        strobes.aluOp = ALU_SUB;
        strobes.wantWrite = 1'b1;
      end
      OPC_AND: begin
        strobes.aluOp = ALU_AND;
        strobes.wantWrite = 1'b1;
      end
      OPC_OR: begin
        strobes.aluOp = ALU_OR;
        strobes.wantWrite = 1'b1;
      end
      OPC_LOAD: begin
        strobes.wantWrite = 1'b1;
        strobes.dstSelRt = 1'b1;
        strobes.aluSrcImm = 1'b1;
        strobes.memLoad = 1'b1;
      end
      OPC_STORE: begin
        strobes.aluSrcImm = 1'b1;
        strobes.memStore = 1'b1;
      end
      OPC_BEQ: begin
        strobes.aluOp = ALU_SUB;
        strobes.branch = 1'b1;
      end
      OPC_JUMP: strobes.jump = 1'b1;
      OPC_HALT: strobes.halt = 1'b1;
      default: ;
    endcase
  end

  // Checks tied to the strobe table
  always_comb begin
    if (!$isunknown(opcode)) begin
      // R5, R6, R8: control-flow flags are mutually exclusive
      a_r8_flow_onehot: assert ($onehot0({strobes.branch, strobes.jump, strobes.halt}))
        else $error("control-flow flags overlap");
      // R4: a store never requests a register write or a load
      a_r4_store_quiet: assert (!strobes.memStore || (!strobes.wantWrite && !strobes.memLoad))
        else $error("store raised a write or load");
      // R3: a load always uses the immediate operand and the Rt destination
      a_r3_load_imm: assert (!strobes.memLoad || (strobes.aluSrcImm && strobes.dstSelRt))
        else $error("load without immediate operand");
    end
  end

endmodule

// File: rtl/dec_fields.sv
module dec_fields #(
  parameter int REG_AW    = 4,
  parameter int DATA_W    = 16,
  parameter int OPC_W     = 4,
  parameter int PROT_REGS = 2
) (
  input  logic [OPC_W+3*REG_AW-1:0]  instrWord,
  input  logic                       wantWrite,
  input  logic                       dstSelRt,
  output logic [REG_AW-1:0]          rsAddr,
  output logic [REG_AW-1:0]          rtAddr,
  output logic [REG_AW-1:0]          rdAddr,
  output logic [REG_AW-1:0]          wrAddr,
  output logic [DATA_W-1:0]          immExt,
  output logic [3*REG_AW-1:0]        jumpOffset,
  output logic                       regWrite
);

  localparam int RD_LO = 0;
  localparam int RT_LO = REG_AW;
  localparam int RS_LO = 2 * REG_AW;
  localparam int JMP_W = 3 * REG_AW;
  localparam int EXT_W = DATA_W - REG_AW;

  assign rsAddr     = instrWord[RS_LO +: REG_AW];
  assign rtAddr     = instrWord[RT_LO +: REG_AW];
  assign rdAddr     = instrWord[RD_LO +: REG_AW];
  assign jumpOffset = instrWord[JMP_W-1:0];
  assign immExt     = {{EXT_W{rdAddr[REG_AW-1]}}, rdAddr};
  assign wrAddr     = dstSelRt ? rtAddr : rdAddr;

  logic [PROT_REGS-1:0] protHit;

  for (genvar g = 0; g < PROT_REGS; g++) begin : g_prot
    assign protHit[g] = (wrAddr == REG_AW'(g));
  end

  assign regWrite = wantWrite && !(|protHit);

  always_comb begin
    if (!$isunknown(instrWord)) begin
      // R9: hardwired registers are never written
      a_r9_protect: assert (!regWrite || (int'(wrAddr) >= PROT_REGS))
        else $error("write enabled to a hardwired register");
      // R7: the extension bits all copy the offset sign
      a_r7_sign_fill: assert (immExt[DATA_W-1:REG_AW] == '0 || immExt[DATA_W-1:REG_AW] == '1)
        else $error("mixed sign-extension bits");
    end
  end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
#(
  parameter int REG_AW    = 4,
  parameter int DATA_W    = 16,
  parameter int PROT_REGS = 2
) (
  input  logic [$bits(opcodeT)+3*REG_AW-1:0] instrWord,
  output logic [1:0]                         aluOp,
  output logic                               regWrite,
  output logic                               dstSelRt,
  output logic [REG_AW-1:0]                  wrAddr,
  output logic                               aluSrcImm,
  output logic                               memLoad,
  output logic                               memStore,
  output logic                               branchFlag,
  output logic                               jumpFlag,
  output logic                               haltFlag,
  output logic [REG_AW-1:0]                  rsAddr,
  output logic [REG_AW-1:0]                  rtAddr,
  output logic [REG_AW-1:0]                  rdAddr,
  output logic [DATA_W-1:0]                  immExt,
  output logic [3*REG_AW-1:0]                jumpOffset
);

  localparam int OPC_W   = $bits(opcodeT);
  localparam int INSTR_W = OPC_W + 3 * REG_AW;

  ctrlStrobesT strobes;

  dec_ctrl u_ctrl (
    .opcode  (instrWord[INSTR_W-1 -: OPC_W]),
    .strobes (strobes)
  );

  dec_fields #(
    .REG_AW    (REG_AW),
    .DATA_W    (DATA_W),
    .OPC_W     (OPC_W),
    .PROT_REGS (PROT_REGS)
  ) u_fields (
    .instrWord  (instrWord),
    .wantWrite  (strobes.wantWrite),
    .dstSelRt   (strobes.dstSelRt),
    .rsAddr     (rsAddr),
    .rtAddr     (rtAddr),
    .rdAddr     (rdAddr),
    .wrAddr     (wrAddr),
    .immExt     (immExt),
    .jumpOffset (jumpOffset),
    .regWrite   (regWrite)
  );

  assign aluOp      = strobes.aluOp;
  assign dstSelRt   = strobes.dstSelRt;
  assign aluSrcImm  = strobes.aluSrcImm;
  assign memLoad    = strobes.memLoad;
  assign memStore   = strobes.memStore;
  assign branchFlag = strobes.branch;
  assign jumpFlag   = strobes.jump;
  assign haltFlag   = strobes.halt;

  always_comb begin
    if (!$isunknown(instrWord)) begin
      // R3, R4: memory read and write never together
      a_r4_mem_exclusive: assert (!(memLoad && memStore))
        else $error("load and store both enabled");
      // R5: a branch writes nothing
      a_r5_branch_quiet: assert (!branchFlag || (!regWrite && !memStore && !memLoad))
        else $error("branch enabled a write");
    end
  end

endmodule

// File: tb/test_instr_decoder.sv
module test_instr_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instrWord = '0;

  logic [1:0]  aluOp;
  logic        regWrite, dstSelRt, aluSrcImm, memLoad, memStore;
  logic        branchFlag, jumpFlag, haltFlag;
  logic [3:0]  wrAddr, rsAddr, rtAddr, rdAddr;
  logic [15:0] immExt;
  logic [11:0] jumpOffset;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_decoder i_instr_decoder (
    .instrWord  (instrWord),
    .aluOp      (aluOp),
    .regWrite   (regWrite),
    .dstSelRt   (dstSelRt),
    .wrAddr     (wrAddr),
    .aluSrcImm  (aluSrcImm),
    .memLoad    (memLoad),
    .memStore   (memStore),
    .branchFlag (branchFlag),
    .jumpFlag   (jumpFlag),
    .haltFlag   (haltFlag),
    .rsAddr     (rsAddr),
    .rtAddr     (rtAddr),
    .rdAddr     (rdAddr),
    .immExt     (immExt),
    .jumpOffset (jumpOffset)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s word=%h act=%h exp=%h", tag, what, instrWord, act, exp);
    end
  endtask

  // Expected control vector:
  // {aluOp[1:0], regWrite, dstSelRt, aluSrcImm, memLoad, memStore, branch, jump, halt}
  function automatic logic [9:0] modelCtrl(input logic [15:0] w);
    logic [3:0] op = w[15:12];
    logic [3:0] dst;
    logic [9:0] v = '0;
    case (op)
      4'b0010: v = {2'b00, 1'b1, 7'b0};
      4'b0011: v = {2'b01, 1'b1, 7'b0};
      4'b0100: v = {2'b10, 1'b1, 7'b0};
      4'b0101: v = {2'b11, 1'b1, 7'b0};
      4'b0000: v = {2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0};
      4'b0001: v = {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b0};
      4'b0111: v = {2'b01, 5'b0, 3'b100};
      4'b1000: v = {2'b00, 5'b0, 3'b010};
      4'b1111: v = {2'b00, 5'b0, 3'b001};
      default: v = '0;
    endcase
    dst = (op == 4'b0000) ? w[7:4] : w[3:0];
    if (dst == 4'd0 || dst == 4'd1) v[7] = 1'b0;
    return v;
  endfunction

  function automatic string tagFor(input logic [3:0] op);
    case (op)
      4'b0000: return "R3";
      4'b0001: return "R4";
      4'b0010, 4'b0011, 4'b0100, 4'b0101: return "R2";
      4'b0111: return "R5";
      4'b1000: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic applyWord(input logic [15:0] w);
    @(negedge clk);
    instrWord = w;
    #1;
    check(tagFor(w[15:12]), "ctrl",
          {22'b0, aluOp, regWrite, dstSelRt, aluSrcImm, memLoad, memStore,
           branchFlag, jumpFlag, haltFlag},
          {22'b0, modelCtrl(w)});
    check("R1", "fields", {20'b0, rsAddr, rtAddr, rdAddr}, {20'b0, w[11:0]});
    check("R9", "wrAddr", {28'b0, wrAddr},
          {28'b0, (w[15:12] == 4'b0000) ? w[7:4] : w[3:0]});
    check("R7", "immExt", {16'b0, immExt}, {16'b0, {12{w[3]}}, w[3:0]});
    check("R6", "jumpOffset", {20'b0, jumpOffset}, {20'b0, w[11:0]});
  endtask

  task automatic sweepOpcode(input logic [3:0] op);
    for (int f = 0; f < 4096; f++) applyWord({op, 12'(f)});
  endtask

  task automatic testReset();
    // R3: the all-zero word is a load into register 0, so no write
    applyWord(16'h0000);
    check("R3", "reset regWrite", {31'b0, regWrite}, 32'd0);
  endtask

  task automatic testArith();
    for (int op = 2; op <= 5; op++) sweepOpcode(4'(op));
  endtask

  task automatic testMemory();
    sweepOpcode(4'b0000);
    sweepOpcode(4'b0001);
  endtask

  task automatic testFlow();
    sweepOpcode(4'b0111);
    sweepOpcode(4'b1000);
  endtask

  task automatic testUnused();
    sweepOpcode(4'b0110);
    for (int op = 9; op <= 15; op++) sweepOpcode(4'(op));
  endtask

  task automatic testOffsets();
    applyWord(16'h0348);
    check("R7", "offset -8", {16'b0, immExt}, 32'h0000FFF8);
    applyWord(16'h712E);
    check("R7", "offset -2", {16'b0, immExt}, 32'h0000FFFE);
    applyWord(16'h1237);
    check("R7", "offset +7", {16'b0, immExt}, 32'h00000007);
  endtask

  task automatic testProtect();
    // R9: load into r1 with a free low field: blocked
    applyWord(16'h0519);
    check("R9", "load to r1", {31'b0, regWrite}, 32'd0);
    // R9: arithmetic into r9 with r1 in the Rt field: allowed
    applyWord(16'h2519);
    check("R9", "add to r9", {31'b0, regWrite}, 32'd1);
    // R9: arithmetic into r0 and r1 blocked, r2 allowed
    applyWord(16'h3450);
    check("R9", "sub to r0", {31'b0, regWrite}, 32'd0);
    applyWord(16'h4451);
    check("R9", "and to r1", {31'b0, regWrite}, 32'd0);
    applyWord(16'h5452);
    check("R9", "or to r2", {31'b0, regWrite}, 32'd1);
    // R9: load into r2 with r0 in the low field: allowed
    applyWord(16'h0320);
    check("R9", "load to r2", {31'b0, regWrite}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testReset();
    testOffsets();
    testProtect();
    testArith();
    testMemory();
    testFlow();
    testUnused();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule